// File: doc/BRIEF.md
# Selectable-Order Sinc Decimator

This block turns a stream of one-bit sigma-delta samples into signed decimated words. Each accepted bit counts as +1 or -1 and feeds a chain of three running-sum integrators. Once every R accepted samples, a comb stage builds the result of the selected filter order. The order can be first, second or third, or a low-latency second-order variant that averages two second-order results taken half a period apart. The ratio R can be set from 1 to 256.

The result is either the full 32-bit value or a 16-bit value. The 16-bit value is an arithmetic right shift of the result, clipped to the signed 16-bit range, with a flag raised when clipping occurs. A restart pulse clears all filter state and the phase counter. The first decimated outputs after a restart rest on zero-padded history, so the block holds them back. The number held back depends on the order. Configuration inputs are expected to change only together with a restart.

Top module: `sinc_decim`

## Requirements
- R1: An input bit of 1 contributes +1 and a bit of 0 contributes -1. With first order and ratio R, a stream of all ones yields +R and a stream of all zeros yields -R.
- R2: The ratio is osr_m1_i+1 (1 to 256). Exactly one decimation event occurs per R accepted samples, counted from the last restart. The event's output appears with vld_o high for one cycle, the cycle after the clock edge that accepts the R-th sample.
- R3: A sample is accepted only when bit_vld_i is high. vld_o is never high in the cycle after an edge at which no sample was accepted.
- R4: ftype_i 0, 1 and 2 select first, second and third order. The output at sample n is the width-R moving sum applied once, twice or three times to the ±1 stream since the restart, with zero before it. This gives a gain of R, R² and R³.
- R5: ftype_i 3 selects the fast second order. Its output is floor((s2[n] + s2[n-h]) / 2), where s2 is the second-order moving sum, h = floor(R/2), and s2 is zero before the restart. When R = 1 the two terms are the same.
- R6: Reset or a restart clears the integrators, combs, phase counter and settle count. vld_o and sat_o are 0 after reset. After a restart the first 0, 1, 2 and 2 decimation events are suppressed for ftype_i 0, 1, 2 and 3 respectively.
- R7: A restart in the same cycle as a valid sample wins: the sample is discarded, no output is produced from it, and counting restarts from zero.
- R8: With out16_i low, data_o carries the full signed result and sat_o stays 0.
- R9: With out16_i high, the result is shifted right arithmetically by shift_i and clipped to -32768..32767. data_o carries that value sign-extended to 32 bits. sat_o is 1 with vld_o exactly when clipping changed the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous restart of filter state |
| bit_vld_i | input | 1 | Modulator sample strobe |
| bit_i | input | 1 | Modulator bit |
| ftype_i | input | 2 | Filter type: 0 first, 1 second, 2 third order, 3 fast second order |
| osr_m1_i | input | 8 | Decimation ratio minus one |
| out16_i | input | 1 | Select shifted, saturated 16-bit output |
| shift_i | input | 5 | Right shift for 16-bit output |
| vld_o | output | 1 | Decimated word valid |
| data_o | output | 32 | Decimated word (sign-extended in 16-bit mode) |
| sat_o | output | 1 | 16-bit result was clipped |

## Verification
Two events can collide in one cycle: a restart and the sample that would complete a decimation period. The bench drives both together at the exact sample position where an output is due. It then requires no output in the next cycle and a fresh count of R samples and settle events afterwards. A second pair is saturation landing on a valid output. Third-order runs on constant input with shifts placed on either side of the 16-bit limit (2^24 shifted by 9 clips, by 10 does not, and -2^24 shifted by 9 lands exactly on -32768) test where the flag starts to be set.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
  typedef enum logic [1:0] {
    FT_SINC1 = 2'd0,
    FT_SINC2 = 2'd1,
    FT_SINC3 = 2'd2,
    FT_FAST2 = 2'd3
  } ftype_e;

  function automatic logic [1:0] settle_need(ftype_e t);
    case (t)
      FT_SINC1: settle_need = 2'd0;
      FT_SINC2: settle_need = 2'd1;
      default:  settle_need = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/sinc_integ.sv
module sinc_integ #(
  parameter int ACC_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic                    bit_i,
  output logic signed [ACC_W-1:0] n1_o,
  output logic signed [ACC_W-1:0] n2_o,
  output logic signed [ACC_W-1:0] n3_o
);
  logic signed [ACC_W-1:0] a1, a2, a3, x;

  // outputs already include the sample being accepted
  always_comb begin
    x    = bit_i ? ACC_W'(1) : '1;
    n1_o = a1 + x;
    n2_o = a2 + n1_o;
    n3_o = a3 + n2_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a1 <= '0; a2 <= '0; a3 <= '0;
    end else if (clr_i) begin
      a1 <= '0; a2 <= '0; a3 <= '0;
    end else if (en_i) begin
      a1 <= n1_o; a2 <= n2_o; a3 <= n3_o;
    end
  end
endmodule

// File: rtl/sinc_comb.sv
module sinc_comb
  import sinc_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    tick_i,
  input  logic                    half_i,
  input  logic                    use_half_i,
  input  ftype_e                  ftype_i,
  input  logic signed [ACC_W-1:0] n1_i,
  input  logic signed [ACC_W-1:0] n2_i,
  input  logic signed [ACC_W-1:0] n3_i,
  output logic signed [ACC_W-1:0] res_o
);
  logic signed [ACC_W-1:0] d1a, d2a, d2b, d3a, d3b, d3c;
  logic signed [ACC_W-1:0] hz1, hz2, hval;
  logic signed [ACC_W-1:0] m1, m2, m3, hm, fsum;

  always_comb begin
    m1   = n1_i - d1a;
    m2   = n2_i - (d2a <<< 1) + d2b;
    m3   = n3_i - ((d3a <<< 1) + d3a) + ((d3b <<< 1) + d3b) - d3c;
    hm   = n2_i - (hz1 <<< 1) + hz2;
    fsum = m2 + (use_half_i ? hval : m2);
    case (ftype_i)
      FT_SINC1: res_o = m1;
      FT_SINC2: res_o = m2;
      FT_SINC3: res_o = m3;
      default:  res_o = fsum >>> 1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d1a <= '0; d2a <= '0; d2b <= '0; d3a <= '0; d3b <= '0; d3c <= '0;
      hz1 <= '0; hz2 <= '0; hval <= '0;
    end else if (clr_i) begin
      d1a <= '0; d2a <= '0; d2b <= '0; d3a <= '0; d3b <= '0; d3c <= '0;
      hz1 <= '0; hz2 <= '0; hval <= '0;
    end else begin
      if (tick_i) begin
        d1a <= n1_i;
        d2b <= d2a; d2a <= n2_i;
        d3c <= d3b; d3b <= d3a; d3a <= n3_i;
      end
      if (half_i) begin
        hval <= hm;
        hz2  <= hz1; hz1 <= n2_i;
      end
    end
  end

  // R5: half-phase capture never coincides with the main decimation event
  p_half_apart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_i |-> !tick_i);
endmodule

// File: rtl/sinc_outfmt.sv
module sinc_outfmt #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 16,
  parameter int SH_W  = 5
) (
  input  logic                    out16_i,
  input  logic [SH_W-1:0]         shift_i,
  input  logic signed [ACC_W-1:0] y_i,
  output logic [ACC_W-1:0]        data_o,
  output logic                    sat_o
);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic signed [ACC_W-1:0] sh, cl;

  always_comb begin
    sh    = y_i >>> shift_i;
    sat_o = 1'b0;
    cl    = sh;
    if (sh > MAXV) begin
      cl = MAXV; sat_o = 1'b1;
    end else if (sh < MINV) begin
      cl = MINV; sat_o = 1'b1;
    end
    if (out16_i) data_o = {{(ACC_W-OUT_W){cl[OUT_W-1]}}, cl[OUT_W-1:0]};
    else begin
      data_o = y_i;
      sat_o  = 1'b0;
    end
  end
endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
  import sinc_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OSR_W = 8,
  parameter int SH_W  = 5,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic [1:0]       ftype_i,
  input  logic [OSR_W-1:0] osr_m1_i,
  input  logic             out16_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic             vld_o,
  output logic [ACC_W-1:0] data_o,
  output logic             sat_o
);
  localparam int MAX16 = (2 ** (OUT_W - 1)) - 1;

  ftype_e                  ftype;
  logic [OSR_W-1:0]        cnt;
  logic [OSR_W:0]          osr_p1, half_w, half_pos;
  logic                    use_half, acc, tick, half, emit;
  logic [1:0]              settle;
  logic signed [ACC_W-1:0] n1, n2, n3, res;
  logic [ACC_W-1:0]        fmt_data;
  logic                    fmt_sat;

  always_comb begin
    ftype    = ftype_e'(ftype_i);
    osr_p1   = {1'b0, osr_m1_i} + 1'b1;
    half_w   = osr_p1 >> 1;
    half_pos = {1'b0, osr_m1_i} - half_w;
    use_half = (half_w != '0);
    acc      = bit_vld_i && !restart_i;
    tick     = acc && (cnt == osr_m1_i);
    half     = acc && use_half && ({1'b0, cnt} == half_pos);
    emit     = tick && (settle >= settle_need(ftype));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0; settle <= '0;
    end else if (restart_i) begin
      cnt <= '0; settle <= '0;
    end else if (acc) begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick && settle != 2'd3) settle <= settle + 1'b1;
    end
  end

  sinc_integ #(.ACC_W(ACC_W)) u_integ (
    .clk_i, .rst_ni, .clr_i(restart_i), .en_i(acc), .bit_i,
    .n1_o(n1), .n2_o(n2), .n3_o(n3)
  );

  sinc_comb #(.ACC_W(ACC_W)) u_comb (
    .clk_i, .rst_ni, .clr_i(restart_i), .tick_i(tick), .half_i(half),
    .use_half_i(use_half), .ftype_i(ftype),
    .n1_i(n1), .n2_i(n2), .n3_i(n3), .res_o(res)
  );

  sinc_outfmt #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_fmt (
    .out16_i, .shift_i, .y_i(res), .data_o(fmt_data), .sat_o(fmt_sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0; data_o <= '0; sat_o <= 1'b0;
    end else begin
      vld_o <= emit;
      sat_o <= emit && fmt_sat;
      if (emit) data_o <= fmt_data;
    end
  end

  p_idle_no_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> !vld_o);
  p_restart_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !vld_o);
  p_sat_with_vld_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> vld_o);
  p_no_sat_wide_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out16_i |=> !sat_o);
  p_range16_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out16_i |=> (!vld_o || ($signed(data_o) <= MAX16 && $signed(data_o) >= -MAX16 - 1)));
endmodule

// File: tb/sim_sinc_decim.sv
`timescale 1ns/1ps
module sim_sinc_decim;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        restart_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0;
  logic [1:0]  ftype_i = 2'd0;
  logic [7:0]  osr_m1_i = 8'd0;
  logic        out16_i = 1'b0;
  logic [4:0]  shift_i = 5'd0;
  logic        vld_o, sat_o;
  logic [31:0] data_o;

  always #2.5 clk_i = ~clk_i;

  sinc_decim u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int xh[4096], m1h[4096], m2h[4096], m3h[4096];
  int n = 0, rr = 1, ty = 0, shc = 0;
  bit o16 = 1'b0;
  bit exp_vld, exp_sat;
  logic [31:0] exp_data;
  string vtag;

  function automatic int hist(ref int a[4096], input int i);
    return (i < 0) ? 0 : a[i];
  endfunction

  function automatic int need();
    return (ty == 0) ? 0 : (ty == 1) ? 1 : 2;
  endfunction

  task automatic model_step(bit b);
    int v, s, t, ticks;
    xh[n] = b ? 1 : -1;
    m1h[n] = 0; m2h[n] = 0; m3h[n] = 0;
    for (int j = 0; j < rr; j++) m1h[n] += hist(xh, n - j);
    for (int j = 0; j < rr; j++) m2h[n] += hist(m1h, n - j);
    for (int j = 0; j < rr; j++) m3h[n] += hist(m2h, n - j);
    ticks = (n + 1) / rr;
    exp_vld = ((n + 1) % rr == 0) && (ticks > need());
    vtag = (ticks <= 2) ? "R6" : "R2";
    case (ty)
      0: v = m1h[n];
      1: v = m2h[n];
      2: v = m3h[n];
      default: begin
        s = m2h[n] + ((rr / 2 > 0) ? hist(m2h, n - rr / 2) : m2h[n]);
        v = s >>> 1;
      end
    endcase
    exp_sat = 1'b0;
    if (o16) begin
      t = v >>> shc;
      if (t > 32767) begin t = 32767; exp_sat = 1'b1; end
      else if (t < -32768) begin t = -32768; exp_sat = 1'b1; end
      exp_data = 32'(t);
    end else exp_data = 32'(v);
    n++;
  endtask

  task automatic check(string dtag);
    n_chk++;
    if (vld_o !== exp_vld) begin
      n_fail++;
      $display("FAIL %s vld_o actual %0b expected %0b", vtag, vld_o, exp_vld);
    end
    if (exp_vld) begin
      n_chk++;
      if (data_o !== exp_data) begin
        n_fail++;
        $display("FAIL %s data_o actual %0d expected %0d", dtag, $signed(data_o), $signed(exp_data));
      end
      n_chk++;
      if (sat_o !== exp_sat) begin
        n_fail++;
        $display("FAIL %s sat_o actual %0b expected %0b", o16 ? "R9" : "R8", sat_o, exp_sat);
      end
    end
  endtask

  // one cycle: drive after a falling edge, judge at the next falling edge
  task automatic cyc(bit v, bit b, bit rs, string dtag);
    bit_vld_i = v; bit_i = b; restart_i = rs;
    if (rs) begin
      n = 0; exp_vld = 1'b0; vtag = v ? "R7" : "R6";
    end else if (v) model_step(b);
    else begin
      exp_vld = 1'b0; vtag = "R3";
    end
    @(negedge clk_i);
    check(dtag);
  endtask

  task automatic setup(int t, int r, bit w16, int sh);
    ty = t; rr = r; o16 = w16; shc = sh;
    ftype_i = 2'(t); osr_m1_i = 8'(r - 1); out16_i = w16; shift_i = 5'(sh);
    cyc(1'b0, 1'b0, 1'b1, "R6");
  endtask

  // pat: 0 random with density dens percent, 1 ones, 2 zeros
  task automatic run_seg(int t, int r, bit w16, int sh, int pat, int dens, string dtag);
    int ns;
    bit b;
    setup(t, r, w16, sh);
    ns = (need() + 4) * r;
    for (int k = 0; k < ns; k++) begin
      if ($urandom % 10 == 0) cyc(1'b0, 1'b0, 1'b0, dtag);
      b = (pat == 1) ? 1'b1 : (pat == 2) ? 1'b0 : (($urandom % 100) < dens);
      cyc(1'b1, b, 1'b0, dtag);
    end
  endtask

  initial begin
    int seed;
    int rsel, t;
    bit w;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk_i);
    // R6: reset state
    n_chk++;
    if (vld_o !== 1'b0 || sat_o !== 1'b0 || data_o !== 32'd0) begin
      n_fail++;
      $display("FAIL R6 reset outputs actual %0b/%0b/%0h expected 0/0/0", vld_o, sat_o, data_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_seg(0, 1, 1'b0, 0, 1, 0, "R1");    // R1: every sample gives +1
    run_seg(0, 8, 1'b0, 0, 2, 0, "R1");    // R1: -R
    run_seg(0, 13, 1'b0, 0, 0, 70, "R4");
    run_seg(1, 16, 1'b0, 0, 0, 30, "R4");
    run_seg(2, 5, 1'b0, 0, 0, 55, "R4");
    run_seg(2, 256, 1'b0, 0, 2, 0, "R8");  // R8: -2^24 in full width
    run_seg(3, 8, 1'b0, 0, 0, 60, "R5");
    run_seg(3, 7, 1'b0, 0, 0, 40, "R5");   // odd ratio
    run_seg(3, 1, 1'b0, 0, 0, 50, "R5");   // no half phase
    run_seg(2, 256, 1'b1, 0, 1, 0, "R9");  // clips to 32767
    run_seg(2, 256, 1'b1, 9, 1, 0, "R9");  // 32768 clips
    run_seg(2, 256, 1'b1, 10, 1, 0, "R9"); // 16384 fits
    run_seg(2, 256, 1'b1, 9, 2, 0, "R9");  // -32768 fits exactly

    // R7: restart together with the sample that would end a period
    setup(0, 4, 1'b0, 0);
    for (int k = 0; k < 7; k++) cyc(1'b1, 1'b1, 1'b0, "R7");
    cyc(1'b1, 1'b1, 1'b1, "R7");
    for (int k = 0; k < 12; k++) cyc(1'b1, k[0], 1'b0, "R7");

    // R6: restart in mid-run re-applies the settle count
    setup(2, 6, 1'b0, 0);
    for (int k = 0; k < 20; k++) cyc(1'b1, 1'b1, 1'b0, "R6");
    cyc(1'b0, 1'b0, 1'b1, "R6");
    for (int k = 0; k < 30; k++) cyc(1'b1, ($urandom % 2) == 1, 1'b0, "R6");

    for (int s = 0; s < 14; s++) begin
      t = $urandom % 4;
      rsel = ($urandom % 4 == 0) ? 1 + $urandom % 256 : 1 + $urandom % 24;
      w = $urandom % 2;
      run_seg(t, rsel, w, $urandom % 21, 0, $urandom % 101,
              w ? "R9" : (t == 3) ? "R5" : "R4");
    end

    bit_vld_i = 1'b0; restart_i = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule